// File: doc/BRIEF.md
# Effective Address Stage

This block is the second stage of a five-stage, word-addressed pipeline. It accepts the instruction word and its program counter from the register behind the fetch stage. It then works out the effective address that later stages use for operand access. The address is a 16-bit displacement added to a base, and the instruction's index field picks that base. An index of zero gives a constant-zero base, so the displacement is an absolute address or an immediate value. An index of all ones gives the instruction's own program counter, which makes the address pc-relative. Any other index reads one register of a general register file through a read port that this stage drives.

The opcode and result-register fields are not used here. They travel beside the computed address in an output register that loads on every clock edge. A synchronous reset clears that register. The register file itself is outside the block: the stage only drives the register number and a "read needed" strobe, and takes the returned word back in the same cycle.

Top module: `ea_calc_stage`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, `out_op`, `out_r` and `out_ea` are all zero after that edge.
- R2: When the index field (instruction bits 19:16) is 0, `rf_req` is low and the effective address is the extended displacement plus zero.
- R3: When the index field is 15, `rf_req` is low and the effective address is the extended displacement plus `in_pc`.
- R4: For an index of 1 to 14, `rf_req` is high and the effective address is the extended displacement plus `rf_data`.
- R5: `rf_idx` always equals the index field, whatever the value of `rf_req`.
- R6: The opcode (bits 31:24) and the result register (bits 23:20) appear unchanged on `out_op` and `out_r`.
- R7: The displacement (bits 15:0) is sign-extended to 32 bits before the add, so a displacement with bit 15 set yields ones in bits 31:16 of a zero-based address.
- R8: When `rf_req` is low, the value on `rf_data` has no effect on `out_ea`.
- R9: When the index is not 15, the value on `in_pc` has no effect on `out_ea`.
- R10: The addition wraps modulo 2^32 and has no carry-out.
- R11: Outputs are registered: the result for the inputs present before a rising edge appears after that edge, one result per cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_pc | input | 32 | Program counter of the instruction being presented |
| in_instr | input | 32 | Instruction word: opcode, result register, index, displacement |
| rf_idx | output | 4 | Register number presented to the register-file read port |
| rf_req | output | 1 | High when the register-file read is needed |
| rf_data | input | 32 | Word returned by the register file for `rf_idx` |
| out_op | output | 8 | Registered opcode |
| out_r | output | 4 | Registered result-register number |
| out_ea | output | 32 | Registered effective address |

## Verification
In every cycle the stage issues the register read for the incoming instruction, and in the same cycle it presents the registered address of the instruction before it. The bench sends back-to-back streams that mix zero-based, pc-relative and register-based instructions. It places deliberately wrong values on `rf_data` and `in_pc` wherever those inputs must be ignored. The strobe and register number are judged a moment after each drive. The registered fields are judged one edge later against a queue of expected entries, so a crossed or delayed result shows up as a mismatch.

// File: rtl/ea_pkg.sv
package ea_pkg;

   // which source feeds the base operand of the address add
   typedef enum logic [1:0] {
      BASE_ZERO = 2'd0,
      BASE_PC   = 2'd1,
      BASE_REG  = 2'd2
   } base_sel_e;

endpackage

// File: rtl/ea_field_split.sv
module ea_field_split #(
   parameter int OP_W   = 8,
   parameter int REG_W  = 4,
   parameter int DISP_W = 16
) (
   input  logic [OP_W+2*REG_W+DISP_W-1:0] instr,
   output logic [OP_W-1:0]                op_f,
   output logic [REG_W-1:0]               r_f,
   output logic [REG_W-1:0]               x_f,
   output logic [DISP_W-1:0]              disp_f
);
   localparam int X_LO  = DISP_W;
   localparam int R_LO  = DISP_W + REG_W;
   localparam int OP_LO = DISP_W + 2*REG_W;

   assign disp_f = instr[DISP_W-1:0];
   assign x_f    = instr[X_LO +: REG_W];
   assign r_f    = instr[R_LO +: REG_W];
   assign op_f   = instr[OP_LO +: OP_W];
endmodule

// File: rtl/ea_base_pick.sv
module ea_base_pick
   import ea_pkg::*;
#(
   parameter int REG_W  = 4,
   parameter int WORD_W = 32
) (
   input  logic [REG_W-1:0]  x_f,
   input  logic [WORD_W-1:0] pc,
   input  logic [WORD_W-1:0] rd_word,
   output logic [REG_W-1:0]  rd_idx,
   output logic              rd_need,
   output base_sel_e         sel,
   output logic [WORD_W-1:0] base
);
   localparam logic [REG_W-1:0] ZERO_IDX = '0;
   localparam logic [REG_W-1:0] PC_IDX   = '1;

   logic hit_zero;
   logic hit_pc;

   assign hit_zero = (x_f == ZERO_IDX);
   assign hit_pc   = (x_f == PC_IDX);

   // register number is offered even when no read is wanted
   assign rd_idx  = x_f;
   assign rd_need = ~(hit_zero | hit_pc);

   always_comb begin
      if (hit_zero)    sel = BASE_ZERO;
      else if (hit_pc) sel = BASE_PC;
      else             sel = BASE_REG;
   end

   always_comb begin
      unique case (sel)
         BASE_ZERO: base = '0;
         BASE_PC:   base = pc;
         default:   base = rd_word;
      endcase
   end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
   parameter int DISP_W   = 16,
   parameter int WORD_W   = 32,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [DISP_W-1:0] disp,
   input  logic [WORD_W-1:0] base,
   output logic [WORD_W-1:0] sum
);
   localparam int PAD_W = WORD_W - DISP_W;

   logic [WORD_W-1:0] disp_ext;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign disp_ext = disp;
      end else if (SIGN_EXT) begin : g_sext
         assign disp_ext = {{PAD_W{disp[DISP_W-1]}}, disp};
      end else begin : g_zext
         assign disp_ext = {{PAD_W{1'b0}}, disp};
      end
   endgenerate

   // carry out of the top bit is dropped: modular add
   assign sum = disp_ext + base;
endmodule

// File: rtl/ea_calc_stage.sv
module ea_calc_stage
   import ea_pkg::*;
#(
   parameter int OP_W     = 8,
   parameter int REG_W    = 4,
   parameter int DISP_W   = 16,
   parameter int WORD_W   = 32,
   parameter bit SIGN_EXT = 1'b1,
   localparam int INSTR_W = OP_W + 2*REG_W + DISP_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [WORD_W-1:0]  in_pc,
   input  logic [INSTR_W-1:0] in_instr,
   output logic [REG_W-1:0]   rf_idx,
   output logic               rf_req,
   input  logic [WORD_W-1:0]  rf_data,
   output logic [OP_W-1:0]    out_op,
   output logic [REG_W-1:0]   out_r,
   output logic [WORD_W-1:0]  out_ea
);
   localparam logic [REG_W-1:0] PC_IDX = '1;

   generate
      if (WORD_W < DISP_W) begin : g_bad_width
         $error("ea_calc_stage: WORD_W must be at least DISP_W");
      end
      if (REG_W < 2) begin : g_bad_regw
         $error("ea_calc_stage: REG_W must allow two reserved indices plus registers");
      end
   endgenerate

   logic [OP_W-1:0]   op_f;
   logic [REG_W-1:0]  r_f;
   logic [REG_W-1:0]  x_f;
   logic [DISP_W-1:0] disp_f;
   logic [WORD_W-1:0] base_w;
   logic [WORD_W-1:0] ea_next;
   base_sel_e         sel_w;

   ea_field_split #(.OP_W(OP_W), .REG_W(REG_W), .DISP_W(DISP_W)) split_i (
      .instr  (in_instr),
      .op_f   (op_f),
      .r_f    (r_f),
      .x_f    (x_f),
      .disp_f (disp_f)
   );

   ea_base_pick #(.REG_W(REG_W), .WORD_W(WORD_W)) pick_i (
      .x_f     (x_f),
      .pc      (in_pc),
      .rd_word (rf_data),
      .rd_idx  (rf_idx),
      .rd_need (rf_req),
      .sel     (sel_w),
      .base    (base_w)
   );

   ea_adder #(.DISP_W(DISP_W), .WORD_W(WORD_W), .SIGN_EXT(SIGN_EXT)) add_i (
      .disp (disp_f),
      .base (base_w),
      .sum  (ea_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_op <= '0;
         out_r  <= '0;
         out_ea <= '0;
      end else begin
         out_op <= op_f;
         out_r  <= r_f;
         out_ea <= ea_next;
      end
   end

   // R2
   zero_idx_noread_chk: assert property (@(posedge clk) disable iff (rst)
      (in_instr[DISP_W +: REG_W] == '0) |-> !rf_req);

   // R3
   pc_idx_noread_chk: assert property (@(posedge clk) disable iff (rst)
      (in_instr[DISP_W +: REG_W] == PC_IDX) |-> !rf_req);

   // R4
   reg_sel_read_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_w == BASE_REG) |-> rf_req);

   // R5
   idx_follows_instr_chk: assert property (@(posedge clk) disable iff (rst)
      rf_idx == in_instr[DISP_W +: REG_W]);

   // R6
   fields_pass_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_op == $past(in_instr[INSTR_W-1 -: OP_W]))
               && (out_r == $past(in_instr[DISP_W+REG_W +: REG_W])));

   // R8
   ignore_rfdata_chk: assert property (@(posedge clk) disable iff (rst)
      (!rf_req && $stable(in_instr) && $stable(in_pc)) |=> $stable(out_ea));
endmodule

// File: tb/ea_calc_stage_tb_top.sv
`timescale 1ns/1ps
module ea_calc_stage_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] in_pc;
   logic [31:0] in_instr;
   logic [3:0]  rf_idx;
   logic        rf_req;
   logic [31:0] rf_data;
   logic [7:0]  out_op;
   logic [3:0]  out_r;
   logic [31:0] out_ea;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [43:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   ea_calc_stage dut_i (
      .clk(clk), .rst(rst), .in_pc(in_pc), .in_instr(in_instr),
      .rf_idx(rf_idx), .rf_req(rf_req), .rf_data(rf_data),
      .out_op(out_op), .out_r(out_r), .out_ea(out_ea)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: applies one instruction, checks the read port, queues the result
   task automatic drive(input string tag, input logic [7:0] op, input logic [3:0] r,
                        input logic [3:0] x, input logic [15:0] disp,
                        input logic [31:0] pc, input logic [31:0] rfd);
      logic [31:0] ext;
      logic [31:0] ea;
      @(negedge clk);
      in_instr = {op, r, x, disp};
      in_pc    = pc;
      rf_data  = rfd;
      ext = {{16{disp[15]}}, disp};
      if (x == 4'd0)       ea = ext;
      else if (x == 4'hF)  ea = ext + pc;
      else                 ea = ext + rfd;
      exp_q.push_back({op, r, ea});
      tag_q.push_back(tag);
      #1;
      check("R5", "rf_idx", {28'd0, rf_idx}, {28'd0, x});
      check((x == 4'd0) ? "R2" : (x == 4'hF) ? "R3" : "R4", "rf_req",
            {31'd0, rf_req}, {31'd0, (x != 4'd0) && (x != 4'hF)});
   endtask

   // monitor: compares registered outputs one edge after each drive (R11)
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [43:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check("R6", "out_op", {24'd0, out_op}, {24'd0, e[43:36]});
            check("R6", "out_r",  {28'd0, out_r},  {28'd0, e[35:32]});
            check(t, "out_ea", out_ea, e[31:0]);
         end
      end
   end

   task automatic reset_and_check(input string tag);
      @(negedge clk);
      rst = 1'b1;
      in_instr = 32'hA5_7_3_1234;
      rf_data  = 32'h1111_1111;
      @(posedge clk);
      #5;
      check(tag, "out_op", {24'd0, out_op}, 32'd0);
      check(tag, "out_r",  {28'd0, out_r},  32'd0);
      check(tag, "out_ea", out_ea, 32'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      in_pc = '0;
      in_instr = '0;
      rf_data = '0;
      repeat (2) @(posedge clk);
      reset_and_check("R1");

      // zero base, positive and negative displacement, junk on rf_data/pc
      drive("R2", 8'h12, 4'h3, 4'h0, 16'h0040, 32'h0000_1000, 32'hDEAD_BEEF);
      drive("R7", 8'h34, 4'h5, 4'h0, 16'h8000, 32'h0000_2000, 32'h0BAD_F00D);
      drive("R8", 8'h56, 4'h7, 4'h0, 16'h7FFF, 32'h1234_5678, 32'hFFFF_FFFF);
      // pc-relative, including wrap
      drive("R3",  8'h78, 4'h9, 4'hF, 16'h0010, 32'h0000_0100, 32'hCAFE_0000);
      drive("R3",  8'h9A, 4'hB, 4'hF, 16'hFFFC, 32'h0000_0100, 32'h0000_0001);
      drive("R10", 8'hBC, 4'hD, 4'hF, 16'h0020, 32'hFFFF_FFF0, 32'h7777_7777);
      // every real register index, back to back, with junk pc
      for (int i = 1; i < 15; i++) begin
         drive("R4", 8'(i * 17), 4'(15 - i), 4'(i), 16'(i * 16'h0111),
               32'hABCD_0000 + i, 32'h0001_0000 * i);
      end
      drive("R9",  8'hC3, 4'h1, 4'h6, 16'hFFF0, 32'hFFFF_FFFF, 32'h0000_0008);
      drive("R10", 8'hE1, 4'h2, 4'h2, 16'h0001, 32'h0000_0000, 32'hFFFF_FFFF);
      // alternating kinds to provoke crossed results
      drive("R11", 8'h01, 4'h4, 4'h0, 16'h1111, 32'h5555_5555, 32'h9999_9999);
      drive("R11", 8'h02, 4'h8, 4'hF, 16'h2222, 32'h1000_0000, 32'h9999_9999);
      drive("R11", 8'h03, 4'hC, 4'h7, 16'h3333, 32'h2000_0000, 32'h4000_0000);
      drive("R11", 8'h04, 4'hE, 4'h0, 16'h4444, 32'h3000_0000, 32'h5000_0000);

      repeat (3) @(posedge clk);
      reset_and_check("R1");
      drive("R6", 8'hFF, 4'hF, 4'h5, 16'h0000, 32'h0, 32'h8765_4321);
      repeat (3) @(posedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule